// File: doc/BRIEF.md
# Serial IQ Framed Serializer

This block turns a stream of paired I and Q words into serial bit streams for a device that receives one or two data lines plus a frame marker. Each sample is taken through a valid/ready handshake and then shifted out one bit per clock. A companion marker line flags the first clock of every sample, so the receiver can find word boundaries.

Three mappings are offered. The two-line mapping sends I on line 0 and Q on line 1 side by side. The block mapping sends the whole I word on line 0 and then the whole Q word. The woven mapping alternates on line 0: each I bit is followed by its Q bit. Bit order and frame-marker polarity can be chosen. Mapping and order are captured with each sample. Polarity applies at once. Samples follow one another with no idle clocks while the source keeps supplying them. When the source runs dry, the lines fall quiet.

The controller has five states. `ST_IDLE` means no sample is held. `ST_DUAL` is the two-line transfer. `ST_BLK_I` and `ST_BLK_Q` are the two halves of the block mapping. `ST_WEAVE` is the woven transfer. The transitions are as follows:
- The *start* transition runs from `ST_IDLE`, or from the last bit of any transfer, into the state picked by the mapping when a sample is accepted.
- The *half* transition runs from `ST_BLK_I` to `ST_BLK_Q` after the last I bit.
- The *drain* transition runs from the last bit back to `ST_IDLE` when no sample is offered.
- The *hold* transition keeps the state and counts the next bit.

Top module: `iq_serial_framer`

## Requirements
- R1: After reset, both data lines are low, the frame marker is inactive and `s_ready` is high.
- R2: With `cfg_map` 0 (code 3 behaves the same), bit k of I appears on `line0` and bit k of Q appears on `line1` in the same clock. A sample lasts WORD_W clocks.
- R3: With `cfg_map` 1, the WORD_W bits of I leave on `line0`, followed immediately by the WORD_W bits of the same sample's Q. A sample lasts 2*WORD_W clocks.
- R4: With `cfg_map` 2, `line0` carries I bit k and then Q bit k, for each k in turn. A sample lasts 2*WORD_W clocks.
- R5: The frame marker is active during exactly one clock per sample: the first clock of that sample, which is the clock after the sample is accepted.
- R6: With `cfg_frame_neg` 0 the marker is active high. With `cfg_frame_neg` 1 it is active low. A change of this input takes effect in the same clock.
- R7: With `cfg_msb_first` 0, bit 0 is sent first. With `cfg_msb_first` 1, bit WORD_W-1 is sent first. For the woven mapping, the order applies to the pair index.
- R8: In mappings 1 and 2, `line1` stays low.
- R9: `s_ready` is high while idle and during the last clock of a sample. A sample accepted in that last clock has its first bit in the very next clock.
- R10: If no sample is offered at a sample boundary, both lines go low and the marker stays inactive until a sample is accepted.
- R11: The mapping and bit order are captured when a sample is accepted. Changing them during a sample does not alter that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample can be taken this clock |
| s_i | input | WORD_W | I word |
| s_q | input | WORD_W | Q word |
| cfg_map | input | 2 | 0 two-line, 1 block, 2 woven, 3 as 0 |
| cfg_msb_first | input | 1 | 1 sends the MSB first |
| cfg_frame_neg | input | 1 | 1 makes the marker active low |
| line0 | output | 1 | Serial data line 0 |
| line1 | output | 1 | Serial data line 1 |
| frame_out | output | 1 | Frame marker |

## Verification
The bench offers samples back to back, with random idle gaps, and changes the mapping and bit order mid-sample after every acceptance. It also flips the marker polarity mid-sample. These stimuli catch several faults:
- A design that inserts a clock between samples fails the ready and frame timing on the boundary clock.
- A design that samples the configuration live emits bits from the wrong position or on the wrong line.
- Word values with only the top or bottom bit set expose swapped bit order.
- Long gaps show whether a drained design keeps repeating old bits or marker pulses.
- Mapping code 3 checks that an unused code falls back to the two-line transfer.

// File: rtl/iqsf_pkg.sv
package iqsf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DUAL  = 3'd1,
        ST_BLK_I = 3'd2,
        ST_BLK_Q = 3'd3,
        ST_WEAVE = 3'd4
    } iqsf_state_e;

    localparam logic [1:0] MAP_DUAL  = 2'd0;
    localparam logic [1:0] MAP_BLOCK = 2'd1;
    localparam logic [1:0] MAP_WEAVE = 2'd2;

endpackage

// File: rtl/iqsf_ctrl.sv
module iqsf_ctrl
    import iqsf_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CW = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [1:0]        cfg_map,
    output iqsf_state_e       state,
    output logic [CW-1:0]     cnt,
    output logic              s_ready,
    output logic              load
);

    localparam logic [CW-1:0] HALF_LAST = CW'(WORD_W - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(2 * WORD_W - 1);

    iqsf_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // end-of-sample detection
    always_comb begin
        unique case (state_q)
            ST_DUAL:  last = (cnt_q == HALF_LAST);
            ST_BLK_Q: last = (cnt_q == HALF_LAST);
            ST_WEAVE: last = (cnt_q == FULL_LAST);
            default:  last = 1'b0;
        endcase
    end

    assign s_ready = (state_q == ST_IDLE) || last;
    assign load    = s_ready && s_valid;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        if (s_ready) begin
            cnt_d = '0;
            if (s_valid) begin
                unique case (cfg_map)
                    MAP_BLOCK: state_d = ST_BLK_I;
                    MAP_WEAVE: state_d = ST_WEAVE;
                    default:   state_d = ST_DUAL;
                endcase
            end else begin
                state_d = ST_IDLE;
            end
        end else if (state_q == ST_BLK_I && cnt_q == HALF_LAST) begin
            state_d = ST_BLK_Q;
            cnt_d   = '0;
        end
    end

    assign state = state_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/iqsf_datapath.sv
module iqsf_datapath
    import iqsf_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CW = $clog2(2 * WORD_W),
    localparam int IW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] i_in,
    input  logic [WORD_W-1:0] q_in,
    input  logic              msb_in,
    input  iqsf_state_e       state,
    input  logic [CW-1:0]     cnt,
    output logic              line0,
    output logic              line1,
    output logic              first
);

    logic [WORD_W-1:0] i_r, q_r;
    logic              msb_r;
    logic [IW-1:0]     k, idx;
    logic              pick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_r   <= '0;
            q_r   <= '0;
            msb_r <= 1'b0;
        end else if (load) begin
            i_r   <= i_in;
            q_r   <= q_in;
            msb_r <= msb_in;
        end
    end

    // outputs
    always_comb begin
        k      = (state == ST_WEAVE) ? cnt[CW-1:1] : cnt[IW-1:0];
        idx    = msb_r ? (IW'(WORD_W - 1) - k) : k;
        pick_q = (state == ST_BLK_Q) || (state == ST_WEAVE && cnt[0]);
        unique case (state)
            ST_IDLE: begin
                line0 = 1'b0;
                line1 = 1'b0;
                first = 1'b0;
            end
            ST_DUAL: begin
                line0 = i_r[idx];
                line1 = q_r[idx];
                first = (cnt == '0);
            end
            ST_BLK_I, ST_WEAVE: begin
                line0 = pick_q ? q_r[idx] : i_r[idx];
                line1 = 1'b0;
                first = (cnt == '0);
            end
            ST_BLK_Q: begin
                line0 = q_r[idx];
                line1 = 1'b0;
                first = 1'b0;
            end
            default: begin
                line0 = 1'b0;
                line1 = 1'b0;
                first = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/iq_serial_framer.sv
module iq_serial_framer
    import iqsf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_i,
    input  logic [WORD_W-1:0] s_q,
    input  logic [1:0]        cfg_map,
    input  logic              cfg_msb_first,
    input  logic              cfg_frame_neg,
    output logic              line0,
    output logic              line1,
    output logic              frame_out
);

    localparam int CW = $clog2(2 * WORD_W);

    iqsf_state_e   fsm_state;
    logic [CW-1:0] bit_cnt;
    logic          load;
    logic          first_bit;

    iqsf_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .cfg_map (cfg_map),
        .state   (fsm_state),
        .cnt     (bit_cnt),
        .s_ready (s_ready),
        .load    (load)
    );

    iqsf_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .i_in   (s_i),
        .q_in   (s_q),
        .msb_in (cfg_msb_first),
        .state  (fsm_state),
        .cnt    (bit_cnt),
        .line0  (line0),
        .line1  (line1),
        .first  (first_bit)
    );

    // polarity is live, not captured
    assign frame_out = first_bit ^ cfg_frame_neg;

endmodule

// File: rtl/iqsf_checker.sv
module iqsf_checker
    import iqsf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic        s_ready,
    input logic        cfg_frame_neg,
    input logic        line0,
    input logic        line1,
    input logic        frame_out,
    input iqsf_state_e fsm_state
);

    logic mark;
    assign mark = (frame_out != cfg_frame_neg);

    a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> s_ready);

    a_r5_mark_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> mark);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> !mark);

    a_r8_line1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BLK_I || fsm_state == ST_BLK_Q || fsm_state == ST_WEAVE) |-> !line1);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> (!line0 && !line1 && !mark));

    a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> (fsm_state == ST_IDLE));

endmodule

bind iq_serial_framer iqsf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .cfg_frame_neg (cfg_frame_neg),
    .line0         (line0),
    .line1         (line1),
    .frame_out     (frame_out),
    .fsm_state     (fsm_state)
);

// File: tb/iq_serial_framer_tb.sv
module iq_serial_framer_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_valid = 1'b0;
    logic         s_ready;
    logic [W-1:0] s_i = '0;
    logic [W-1:0] s_q = '0;
    logic [1:0]   cfg_map = 2'd0;
    logic         cfg_msb_first = 1'b0;
    logic         cfg_frame_neg = 1'b0;
    logic         line0, line1, frame_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // expected bit entries: {mode[1:0], first, l1, l0}
    logic [4:0] exp_q[$];

    always #5 clk = ~clk;

    iq_serial_framer #(.WORD_W(W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_valid       (s_valid),
        .s_ready       (s_ready),
        .s_i           (s_i),
        .s_q           (s_q),
        .cfg_map       (cfg_map),
        .cfg_msb_first (cfg_msb_first),
        .cfg_frame_neg (cfg_frame_neg),
        .line0         (line0),
        .line1         (line1),
        .frame_out     (frame_out)
    );

    // reference model: build the bit list of a sample at acceptance (R11)
    task automatic push_sample(input logic [W-1:0] iv, input logic [W-1:0] qv,
                               input logic [1:0] m, input logic msb);
        logic [1:0] mode;
        mode = (m == 2'd3) ? 2'd0 : m;
        if (mode == 2'd0) begin
            for (int k = 0; k < W; k++) begin
                int b;
                b = msb ? W - 1 - k : k;
                exp_q.push_back({mode, (k == 0), qv[b], iv[b]});
            end
        end else if (mode == 2'd1) begin
            for (int k = 0; k < 2 * W; k++) begin
                int b;
                b = msb ? W - 1 - (k % W) : (k % W);
                exp_q.push_back({mode, (k == 0), 1'b0, (k < W) ? iv[b] : qv[b]});
            end
        end else begin
            for (int k = 0; k < 2 * W; k++) begin
                int b;
                b = msb ? W - 1 - (k / 2) : (k / 2);
                exp_q.push_back({mode, (k == 0), 1'b0, (k % 2 == 1) ? qv[b] : iv[b]});
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            bit acc;
            acc = s_valid && (exp_q.size() <= 1);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (acc) push_sample(s_i, s_q, cfg_map, cfg_msb_first);
        end
    end

    function automatic string mode_tag(input logic [1:0] m);
        if (m == 2'd0) return "R2";
        if (m == 2'd1) return "R3";
        return "R4";
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit       ok;
            bit       er;
            bit [4:0] e;
            bit       ef;
            string    tag;
            er = (exp_q.size() <= 1);
            if (exp_q.size() > 0) begin
                e = exp_q[0];
                tag = mode_tag(e[4:3]);
            end else begin
                e = 5'b0;
                tag = "R10";
            end
            ef = e[2] ^ cfg_frame_neg;
            ok = 1'b1;
            checks++;
            if (line0 !== e[0]) begin
                ok = 1'b0;
                $display("FAIL %s/R7 line0 actual=%b expected=%b", tag, line0, e[0]);
            end
            if (line1 !== e[1]) begin
                ok = 1'b0;
                $display("FAIL %s/R8 line1 actual=%b expected=%b", tag, line1, e[1]);
            end
            if (frame_out !== ef) begin
                ok = 1'b0;
                $display("FAIL R5/R6 frame_out actual=%b expected=%b", frame_out, ef);
            end
            if (s_ready !== er) begin
                ok = 1'b0;
                $display("FAIL R9 s_ready actual=%b expected=%b", s_ready, er);
            end
            if (!ok) fails++;
        end
    end

    // offer one sample, then scramble the config mid-sample (R11)
    task automatic send(input logic [W-1:0] iv, input logic [W-1:0] qv,
                        input logic [1:0] m, input logic msb);
        s_valid = 1'b1;
        s_i = iv;
        s_q = qv;
        cfg_map = m;
        cfg_msb_first = msb;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        @(posedge clk);
        #2;
        s_valid = 1'b0;
        cfg_map = m + 2'd1;
        cfg_msb_first = ~msb;
        s_i = ~iv;
        s_q = ~qv;
    endtask

    task automatic idle(input int n);
        s_valid = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        checks++;
        if (line0 !== 1'b0 || line1 !== 1'b0 || frame_out !== 1'b0 || s_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0001",
                     line0, line1, frame_out, s_ready);
        end
        rst_n = 1'b1;
        idle(2);
        // R2 two-line, LSB and MSB first, back to back (R9)
        send(16'h0001, 16'h8000, 2'd0, 1'b0);
        send(16'h0001, 16'h8000, 2'd0, 1'b1);
        send(16'hA5C3, 16'h3C5A, 2'd3, 1'b0);
        idle(5);   // R10 underrun
        // R3 block
        send(16'h8001, 16'h0F0F, 2'd1, 1'b0);
        send(16'h1234, 16'hFEDC, 2'd1, 1'b1);
        // R4 woven
        send(16'hFFFF, 16'h0000, 2'd2, 1'b0);
        send(16'h00FF, 16'hF0F0, 2'd2, 1'b1);
        idle(3);
        // R6: polarity flips mid-sample
        fork
            send(16'h5555, 16'hAAAA, 2'd1, 1'b0);
            begin
                idle(7);
                cfg_frame_neg = 1'b1;
            end
        join
        send(16'h0001, 16'h0002, 2'd0, 1'b0);
        send(16'h0003, 16'h0004, 2'd2, 1'b1);
        idle(4);
        cfg_frame_neg = 1'b0;
        // mixed random traffic with random gaps
        for (int n = 0; n < 60; n++) begin
            send(W'($urandom), W'($urandom), 2'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) idle($urandom % 20);
            if ($urandom % 8 == 0) cfg_frame_neg = ~cfg_frame_neg;
        end
        idle(40);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule